// File: doc/BRIEF.md
# Sync Completion Notifier

This block sits behind a processor-side register write port of an interrupt controller. Software writes to it to ask for a queue sync or a cache flush. Both operations complete at once in this model. What the block adds is the completion signal: for an inject-type request it writes a single byte of 0xFF into memory. Software then polls that byte.

The target byte lies in a three-level notification area.

- A programmable table of 16 base addresses is indexed by the topology ID of the requesting thread. Each base points to a 64 KB region.
- Inside that region, the requesting thread number picks a 512-byte chunk.
- Inside the chunk, this controller's own chip topology ID picks a 32-byte slot.
- Inside the slot, a per-operation type code gives the byte offset.

Sync requests arrive through a window of two pages that share one layout. The page size is set by a runtime shift input. A write to the lower page is a poll request and produces no memory write. A write that sets any bit above the page mask is an inject request. A second register space holds four cache-flush inject registers, and each of them always notifies.

Only one notification can be outstanding at a time. The request port stays back-pressured until the byte write has been accepted. Two faults are recorded in a sticky status that software clears by writing one: an undecoded offset, and a missing or zero base address.

Top module: `sync_notify_writer`

## Requirements
- R1: After reset, `req_ready_o` is 1, `wr_valid_o` is 0, `err_flag_o` is 0 and `err_cause_o` is 0.
- R2: A decoded sync-window write (`req_space_i`=0) with no offset bit set at or above bit `page_shift_i` is a poll request. It raises neither `wr_valid_o` nor `err_flag_o`.
- R3: A sync-window write that sets any offset bit at or above bit `page_shift_i` is an inject request. The in-page offset selects the type code:
  - 0x000→0x00, 0x080→0x01, 0x100→0x02, 0x180→0x03
  - 0x200→0x04, 0x280→0x05, 0x300→0x06
  - 0x800→0x10, 0x880→0x11, 0x900→0x12, 0x980→0x13, 0xA00→0x14, 0xA80→0x15

  On the clock edge after acceptance, `wr_valid_o` rises. At that point `wr_addr_o` = base[`req_topo_i`] + `req_thread_i`×512 + `chip_topo_i`×32 + code, and `wr_data_o` = 0xFF.
- R4: A write with `req_space_i`=1 addresses the flush register space. Offset 0x00→code 0x08, 0x08→0x09, 0x10→0x0A and 0x18→0x18. These writes always notify, using the same address formula as R3.
- R5: The in-page offset is `req_offset_i` masked to its low `page_shift_i` bits, so changing the shift moves the boundary between the poll page and the inject page.
- R6: A write to an offset that no table decodes sets `err_flag_o` with `err_cause_o`=1 and `err_offset_o` equal to the written offset. It raises no `wr_valid_o`.
- R7: An inject request whose base entry is either marked invalid or holds the value zero sets `err_flag_o` with `err_cause_o`=2 and produces no memory write.
- R8: From acceptance of a notifying request until the clock edge where `wr_valid_o` and `wr_ready_i` are both 1, `req_ready_o` is 0. During that time `wr_valid_o` stays 1 and `wr_addr_o` stays stable.
- R9: `err_clr_i`=1 clears the flag, the cause and the offset. If a new error is recorded on the same edge, the new error wins and the flag stays set.
- R10: A base table write (`tbl_we_i`) updates entry `tbl_idx_i` at the clock edge. A request accepted on that same edge still uses the previous entry. The next request uses the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| chip_topo_i | input | TOPO_W | Topology ID of this controller's chip (slot select) |
| page_shift_i | input | SHIFT_W | Log2 of the sync window page size |
| req_valid_i | input | 1 | Register write request valid |
| req_ready_o | output | 1 | Register write request accepted when high |
| req_space_i | input | 1 | 0 = sync window, 1 = flush register space |
| req_offset_i | input | ADDR_W | Register offset of the write |
| req_thread_i | input | THREAD_W | Requesting thread number (chunk select) |
| req_topo_i | input | TOPO_W | Requesting thread's topology ID (base table index) |
| tbl_we_i | input | 1 | Base table write strobe |
| tbl_idx_i | input | TOPO_W | Base table entry index |
| tbl_base_i | input | MEM_AW | Base address for the entry |
| tbl_valid_i | input | 1 | Valid bit for the entry |
| wr_valid_o | output | 1 | Memory byte write valid |
| wr_ready_i | input | 1 | Memory byte write accepted |
| wr_addr_o | output | MEM_AW | Byte address of the notification |
| wr_data_o | output | 8 | Notification byte (0xFF) |
| err_flag_o | output | 1 | Sticky error flag |
| err_cause_o | output | 2 | 1 = undecoded offset, 2 = missing base |
| err_offset_o | output | ADDR_W | Offset of the last failing write |
| err_clr_i | input | 1 | Write-one-to-clear of the error status |

## Verification
Two pairs of functions can fall on the same clock edge.

- **Error clear and error capture.** The bench drives `err_clr_i` in the very cycle a bad-offset inject is accepted. It expects the flag to stay set, with the new offset and cause.
- **Table write and notification.** The bench programs a base entry on the same edge that an inject from that topology ID is accepted. It expects the emitted address to use the old base, and the following request to use the new base.

// File: rtl/snw_pkg.sv
package snw_pkg;

   typedef logic [4:0] code_t;

   typedef enum logic [1:0] {
      ERR_NONE       = 2'd0,
      ERR_BAD_OFFSET = 2'd1,
      ERR_NO_BASE    = 2'd2
   } err_cause_e;

   typedef struct packed {
      logic  hit;
      code_t code;
   } dec_t;

   // byte geometry of the notification area
   localparam int SLOT_SHIFT  = 5;   // 32-byte slot per target chip
   localparam int CHUNK_SHIFT = 9;   // 512-byte chunk per thread
   localparam int SYNC_OFF_W  = 12;  // width of the sync register layout

   function automatic dec_t sync_lookup(input logic [SYNC_OFF_W-1:0] off);
      dec_t d;
      d.hit  = 1'b1;
      d.code = '0;
      unique case (off)
         12'h000: d.code = 5'h00;
         12'h080: d.code = 5'h01;
         12'h100: d.code = 5'h02;
         12'h180: d.code = 5'h03;
         12'h200: d.code = 5'h04;
         12'h280: d.code = 5'h05;
         12'h300: d.code = 5'h06;
         12'h800: d.code = 5'h10;
         12'h880: d.code = 5'h11;
         12'h900: d.code = 5'h12;
         12'h980: d.code = 5'h13;
         12'hA00: d.code = 5'h14;
         12'hA80: d.code = 5'h15;
         default: d.hit  = 1'b0;
      endcase
      return d;
   endfunction

   function automatic dec_t flush_lookup(input logic [4:0] off);
      dec_t d;
      d.hit  = 1'b1;
      d.code = '0;
      unique case (off)
         5'h00:   d.code = 5'h08;
         5'h08:   d.code = 5'h09;
         5'h10:   d.code = 5'h0A;
         5'h18:   d.code = 5'h18;
         default: d.hit  = 1'b0;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/snw_decoder.sv
module snw_decoder
   import snw_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int SHIFT_W   = 5,
   parameter bit HAS_FLUSH = 1'b1
) (
   input  logic               space_i,
   input  logic [ADDR_W-1:0]  offset_i,
   input  logic [SHIFT_W-1:0] page_shift_i,
   output logic               hit_o,
   output logic               inject_o,
   output code_t              code_o
);

   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   logic [ADDR_W-1:0] page_mask;
   logic [ADDR_W-1:0] in_page;
   logic              above_page;
   dec_t              sync_d;
   dec_t              flush_d;

   if (ADDR_W <= SYNC_OFF_W) begin : g_chk_addr
      $error("snw_decoder: ADDR_W must exceed the sync layout width");
   end

   assign page_mask  = (ONE << page_shift_i) - ONE;
   assign in_page    = offset_i & page_mask;
   assign above_page = |(offset_i & ~page_mask);

   always_comb begin
      sync_d = sync_lookup(in_page[SYNC_OFF_W-1:0]);
      if (in_page[ADDR_W-1:SYNC_OFF_W] != '0) sync_d.hit = 1'b0;
   end

   if (HAS_FLUSH) begin : g_flush
      always_comb begin
         flush_d = flush_lookup(offset_i[4:0]);
         if (offset_i[ADDR_W-1:5] != '0) flush_d.hit = 1'b0;
      end
   end else begin : g_no_flush
      assign flush_d = '0;
   end

   always_comb begin
      if (space_i) begin
         hit_o    = flush_d.hit;
         inject_o = 1'b1;
         code_o   = flush_d.code;
      end else begin
         hit_o    = sync_d.hit;
         inject_o = above_page;
         code_o   = sync_d.code;
      end
   end

endmodule

// File: rtl/snw_base_table.sv
module snw_base_table #(
   parameter int TOPO_W = 4,
   parameter int MEM_AW = 40
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic [TOPO_W-1:0] idx_i,
   input  logic [MEM_AW-1:0] base_i,
   input  logic              valid_i,
   input  logic [TOPO_W-1:0] rd_idx_i,
   output logic [MEM_AW-1:0] rd_base_o,
   output logic              rd_ok_o
);

   localparam int NUM = 1 << TOPO_W;

   logic [NUM-1:0]    vld_all;
   logic [MEM_AW-1:0] base_all [NUM];

   for (genvar e = 0; e < NUM; e++) begin : g_ent
      logic              v_q;
      logic [MEM_AW-1:0] b_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            v_q <= 1'b0;
            b_q <= '0;
         end else if (we_i && (idx_i == TOPO_W'(e))) begin
            v_q <= valid_i;
            b_q <= base_i;
         end
      end
      assign vld_all[e]  = v_q;
      assign base_all[e] = b_q;
   end

   assign rd_base_o = base_all[rd_idx_i];
   assign rd_ok_o   = vld_all[rd_idx_i] && (base_all[rd_idx_i] != '0);

   AST_TBL_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i |=> (vld_all[$past(idx_i)] == $past(valid_i)) && (base_all[$past(idx_i)] == $past(base_i))); // R10

endmodule

// File: rtl/snw_err_status.sv
module snw_err_status
   import snw_pkg::*;
#(
   parameter int ADDR_W = 20
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              set_i,
   input  err_cause_e        cause_i,
   input  logic [ADDR_W-1:0] offset_i,
   input  logic              clr_i,
   output logic              flag_o,
   output err_cause_e        cause_o,
   output logic [ADDR_W-1:0] offset_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flag_o   <= 1'b0;
         cause_o  <= ERR_NONE;
         offset_o <= '0;
      end else if (set_i) begin
         flag_o   <= 1'b1;
         cause_o  <= cause_i;
         offset_o <= offset_i;
      end else if (clr_i) begin
         flag_o   <= 1'b0;
         cause_o  <= ERR_NONE;
         offset_o <= '0;
      end
   end

   AST_ERR_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i |=> flag_o && (cause_o == $past(cause_i))); // R9
   AST_ERR_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !set_i) |=> !flag_o); // R9

endmodule

// File: rtl/sync_notify_writer.sv
module sync_notify_writer
   import snw_pkg::*;
#(
   parameter int ADDR_W         = 20,
   parameter int MEM_AW         = 40,
   parameter int TOPO_W         = 4,
   parameter int THREAD_W       = 7,
   parameter int SHIFT_W        = 5,
   parameter bit HAS_FLUSH_REGS = 1'b1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [TOPO_W-1:0]   chip_topo_i,
   input  logic [SHIFT_W-1:0]  page_shift_i,
   input  logic                req_valid_i,
   output logic                req_ready_o,
   input  logic                req_space_i,
   input  logic [ADDR_W-1:0]   req_offset_i,
   input  logic [THREAD_W-1:0] req_thread_i,
   input  logic [TOPO_W-1:0]   req_topo_i,
   input  logic                tbl_we_i,
   input  logic [TOPO_W-1:0]   tbl_idx_i,
   input  logic [MEM_AW-1:0]   tbl_base_i,
   input  logic                tbl_valid_i,
   output logic                wr_valid_o,
   input  logic                wr_ready_i,
   output logic [MEM_AW-1:0]   wr_addr_o,
   output logic [7:0]          wr_data_o,
   output logic                err_flag_o,
   output logic [1:0]          err_cause_o,
   output logic [ADDR_W-1:0]   err_offset_o,
   input  logic                err_clr_i
);

   localparam int REGION_W = THREAD_W + CHUNK_SHIFT;
   localparam logic [7:0] NOTIFY_BYTE = 8'hFF;

   if (TOPO_W + SLOT_SHIFT > CHUNK_SHIFT) begin : g_chk_topo
      $error("sync_notify_writer: chip slots overflow a thread chunk");
   end
   if (MEM_AW <= REGION_W) begin : g_chk_mem
      $error("sync_notify_writer: MEM_AW too small for the notification region");
   end

   logic              dec_hit;
   logic              dec_inject;
   code_t             dec_code;
   logic [MEM_AW-1:0] tbl_base;
   logic              tbl_ok;
   logic              accept;
   logic              fire;
   logic              err_set;
   err_cause_e        err_cause_d;
   err_cause_e        err_cause_q;
   logic [MEM_AW-1:0] addr_d;
   logic              busy_q;
   logic [MEM_AW-1:0] addr_q;

   snw_decoder #(
      .ADDR_W   (ADDR_W),
      .SHIFT_W  (SHIFT_W),
      .HAS_FLUSH(HAS_FLUSH_REGS)
   ) u_dec (
      .space_i     (req_space_i),
      .offset_i    (req_offset_i),
      .page_shift_i(page_shift_i),
      .hit_o       (dec_hit),
      .inject_o    (dec_inject),
      .code_o      (dec_code)
   );

   snw_base_table #(
      .TOPO_W(TOPO_W),
      .MEM_AW(MEM_AW)
   ) u_tbl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (tbl_we_i),
      .idx_i    (tbl_idx_i),
      .base_i   (tbl_base_i),
      .valid_i  (tbl_valid_i),
      .rd_idx_i (req_topo_i),
      .rd_base_o(tbl_base),
      .rd_ok_o  (tbl_ok)
   );

   assign accept  = req_valid_i && req_ready_o;
   assign fire    = accept && dec_hit && dec_inject && tbl_ok;
   assign err_set = accept && (!dec_hit || (dec_inject && !tbl_ok));
   assign err_cause_d = !dec_hit ? ERR_BAD_OFFSET : ERR_NO_BASE;

   assign addr_d = tbl_base
                 + (MEM_AW'(req_thread_i) << CHUNK_SHIFT)
                 + (MEM_AW'(chip_topo_i) << SLOT_SHIFT)
                 + MEM_AW'(dec_code);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         addr_q <= '0;
      end else if (fire) begin
         busy_q <= 1'b1;
         addr_q <= addr_d;
      end else if (busy_q && wr_ready_i) begin
         busy_q <= 1'b0;
      end
   end

   assign req_ready_o = !busy_q;
   assign wr_valid_o  = busy_q;
   assign wr_addr_o   = addr_q;
   assign wr_data_o   = NOTIFY_BYTE;

   snw_err_status #(
      .ADDR_W(ADDR_W)
   ) u_err (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (err_set),
      .cause_i (err_cause_d),
      .offset_i(req_offset_i),
      .clr_i   (err_clr_i),
      .flag_o  (err_flag_o),
      .cause_o (err_cause_q),
      .offset_o(err_offset_o)
   );
   assign err_cause_o = err_cause_q;

   AST_POLL_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept && !req_space_i && dec_hit && !dec_inject) |=> !wr_valid_o); // R2
   AST_BAD_OFFSET_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept && !dec_hit) |=> !wr_valid_o && err_flag_o); // R6
   AST_NO_BASE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept && dec_hit && dec_inject && !tbl_ok) |=> !wr_valid_o && err_flag_o); // R7
   AST_WRITE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_valid_o && !wr_ready_i) |=> wr_valid_o && $stable(wr_addr_o)); // R8
   AST_NO_ACCEPT_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_valid_o && !wr_ready_i) |=> !req_ready_o); // R8

endmodule

// File: tb/sync_notify_writer_bench.sv
module sync_notify_writer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  chip_topo = 4'd3;
   logic [4:0]  page_shift = 5'd12;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_space = 1'b0;
   logic [19:0] req_offset = '0;
   logic [6:0]  req_thread = '0;
   logic [3:0]  req_topo = '0;
   logic        tbl_we = 1'b0;
   logic [3:0]  tbl_idx = '0;
   logic [39:0] tbl_base = '0;
   logic        tbl_valid = 1'b0;
   logic        wr_valid;
   logic        wr_ready = 1'b0;
   logic [39:0] wr_addr;
   logic [7:0]  wr_data;
   logic        err_flag;
   logic [1:0]  err_cause;
   logic [19:0] err_offset;
   logic        err_clr = 1'b0;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;
   logic [39:0] mdl_base [16];
   logic        mdl_vld  [16];

   always #2.5 clk = ~clk;

   sync_notify_writer u_sync_notify_writer (
      .clk_i(clk), .rst_ni(rst_n), .chip_topo_i(chip_topo), .page_shift_i(page_shift),
      .req_valid_i(req_valid), .req_ready_o(req_ready), .req_space_i(req_space),
      .req_offset_i(req_offset), .req_thread_i(req_thread), .req_topo_i(req_topo),
      .tbl_we_i(tbl_we), .tbl_idx_i(tbl_idx), .tbl_base_i(tbl_base), .tbl_valid_i(tbl_valid),
      .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
      .err_flag_o(err_flag), .err_cause_o(err_cause), .err_offset_o(err_offset),
      .err_clr_i(err_clr)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [39:0] exp_addr(input logic [3:0] topo, input logic [6:0] thr,
                                            input logic [4:0] code);
      return mdl_base[topo] + 40'(thr) * 40'd512 + 40'(chip_topo) * 40'd32 + 40'(code);
   endfunction

   task automatic tbl_write(input logic [3:0] idx, input logic [39:0] base, input logic vld);
      tbl_we = 1'b1; tbl_idx = idx; tbl_base = base; tbl_valid = vld;
      @(posedge clk); @(negedge clk);
      tbl_we = 1'b0;
      mdl_base[idx] = base; mdl_vld[idx] = vld;
   endtask

   task automatic issue(input logic sp, input logic [19:0] off, input logic [6:0] thr,
                        input logic [3:0] topo);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_space = sp; req_offset = off; req_thread = thr; req_topo = topo;
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0;
      err_clr = 1'b0;
      tbl_we = 1'b0;
   endtask

   task automatic finish_write();
      wr_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      wr_ready = 1'b0;
   endtask

   task automatic inject_expect(input string req, input logic sp, input logic [19:0] off,
                                input logic [6:0] thr, input logic [3:0] topo,
                                input logic [4:0] code);
      logic [39:0] ea;
      ea = exp_addr(topo, thr, code);
      issue(sp, off, thr, topo);
      chk({req, " valid"}, 64'(wr_valid), 64'd1);
      chk({req, " addr"}, 64'(wr_addr), 64'(ea));
      chk({req, " data"}, 64'(wr_data), 64'hFF);
      finish_write();
      chk({req, " done"}, 64'(wr_valid), 64'd0);
   endtask

   task automatic t_reset();
      chk("R1 ready", 64'(req_ready), 64'd1);
      chk("R1 wr_valid", 64'(wr_valid), 64'd0);
      chk("R1 err_flag", 64'(err_flag), 64'd0);
      chk("R1 err_cause", 64'(err_cause), 64'd0);
   endtask

   task automatic t_poll();
      issue(1'b0, 20'h00200, 7'd5, 4'd0);
      chk("R2 poll no write", 64'(wr_valid), 64'd0);
      chk("R2 poll no error", 64'(err_flag), 64'd0);
      @(negedge clk);
      chk("R2 poll still no write", 64'(wr_valid), 64'd0);
   endtask

   task automatic t_sync_inject();
      logic [11:0] offs [13] = '{12'h000, 12'h080, 12'h100, 12'h180, 12'h200, 12'h280,
                                 12'h300, 12'h800, 12'h880, 12'h900, 12'h980, 12'hA00, 12'hA80};
      logic [4:0]  codes [13] = '{5'h00, 5'h01, 5'h02, 5'h03, 5'h04, 5'h05, 5'h06,
                                  5'h10, 5'h11, 5'h12, 5'h13, 5'h14, 5'h15};
      for (int i = 0; i < 13; i++) begin
         logic [3:0] tp;
         tp = (i % 3 == 0) ? 4'd0 : ((i % 3 == 1) ? 4'd1 : 4'd15);
         inject_expect("R3 sync inject", 1'b0, 20'h01000 | 20'(offs[i]), 7'((i * 9) % 128),
                       tp, codes[i]);
      end
      chip_topo = 4'd15;
      inject_expect("R3 top thread and chip", 1'b0, 20'h01A80, 7'd127, 4'd15, 5'h15);
      chip_topo = 4'd3;
   endtask

   task automatic t_flush();
      inject_expect("R4 flush end", 1'b1, 20'h00000, 7'd2, 4'd0, 5'h08);
      inject_expect("R4 flush esb", 1'b1, 20'h00008, 7'd3, 4'd1, 5'h09);
      inject_expect("R4 flush eas", 1'b1, 20'h00010, 7'd4, 4'd0, 5'h0A);
      inject_expect("R4 flush nxc", 1'b1, 20'h00018, 7'd5, 4'd1, 5'h18);
   endtask

   task automatic t_page_shift();
      page_shift = 5'd16;
      issue(1'b0, 20'h00900, 7'd1, 4'd0);
      chk("R5 shift16 low page poll", 64'(wr_valid), 64'd0);
      inject_expect("R5 shift16 upper page", 1'b0, 20'h10900, 7'd1, 4'd0, 5'h12);
      issue(1'b0, 20'h01900, 7'd1, 4'd0);
      chk("R5 shift16 bit12 is in-page", 64'(err_cause), 64'd1);
      err_clr = 1'b1; @(posedge clk); @(negedge clk); err_clr = 1'b0;
      page_shift = 5'd12;
      inject_expect("R5 shift12 upper page", 1'b0, 20'h01900, 7'd1, 4'd0, 5'h12);
   endtask

   task automatic t_bad_offset();
      issue(1'b0, 20'h01204, 7'd0, 4'd0);
      chk("R6 no write", 64'(wr_valid), 64'd0);
      chk("R6 flag", 64'(err_flag), 64'd1);
      chk("R6 cause", 64'(err_cause), 64'd1);
      chk("R6 offset", 64'(err_offset), 64'h01204);
      err_clr = 1'b1; @(posedge clk); @(negedge clk); err_clr = 1'b0;
      issue(1'b1, 20'h00004, 7'd0, 4'd0);
      chk("R6 flush space bad offset", 64'(err_cause), 64'd1);
      chk("R6 flush space no write", 64'(wr_valid), 64'd0);
      err_clr = 1'b1; @(posedge clk); @(negedge clk); err_clr = 1'b0;
   endtask

   task automatic t_no_base();
      issue(1'b0, 20'h01000, 7'd0, 4'd3);
      chk("R7 invalid entry no write", 64'(wr_valid), 64'd0);
      chk("R7 invalid entry cause", 64'(err_cause), 64'd2);
      err_clr = 1'b1; @(posedge clk); @(negedge clk); err_clr = 1'b0;
      issue(1'b1, 20'h00008, 7'd0, 4'd2);
      chk("R7 zero base no write", 64'(wr_valid), 64'd0);
      chk("R7 zero base cause", 64'(err_cause), 64'd2);
      chk("R7 zero base offset", 64'(err_offset), 64'h00008);
      err_clr = 1'b1; @(posedge clk); @(negedge clk); err_clr = 1'b0;
   endtask

   task automatic t_backpressure();
      logic [39:0] ea;
      ea = exp_addr(4'd1, 7'd77, 5'h05);
      issue(1'b0, 20'h01280, 7'd77, 4'd1);
      for (int c = 0; c < 3; c++) begin
         req_valid = 1'b1; req_offset = 20'h01000; req_topo = 4'd0;
         chk("R8 held valid", 64'(wr_valid), 64'd1);
         chk("R8 held addr", 64'(wr_addr), 64'(ea));
         chk("R8 ready low", 64'(req_ready), 64'd0);
         @(negedge clk);
      end
      req_valid = 1'b0;
      finish_write();
      chk("R8 released", 64'(req_ready), 64'd1);
      chk("R8 extra request not taken", 64'(wr_valid), 64'd0);
   endtask

   task automatic t_err_clear();
      issue(1'b0, 20'h01004, 7'd0, 4'd0);
      chk("R9 error set", 64'(err_flag), 64'd1);
      err_clr = 1'b1;
      issue(1'b0, 20'h01008, 7'd0, 4'd0);
      chk("R9 set beats clear flag", 64'(err_flag), 64'd1);
      chk("R9 set beats clear offset", 64'(err_offset), 64'h01008);
      err_clr = 1'b1; @(posedge clk); @(negedge clk); err_clr = 1'b0;
      chk("R9 cleared flag", 64'(err_flag), 64'd0);
      chk("R9 cleared cause", 64'(err_cause), 64'd0);
   endtask

   task automatic t_tbl_collide();
      logic [39:0] ea_old;
      ea_old = exp_addr(4'd5, 7'd9, 5'h00);
      tbl_we = 1'b1; tbl_idx = 4'd5; tbl_base = 40'h55_0000; tbl_valid = 1'b1;
      issue(1'b0, 20'h01000, 7'd9, 4'd5);
      mdl_base[5] = 40'h55_0000;
      chk("R10 same-edge uses old base", 64'(wr_addr), 64'(ea_old));
      finish_write();
      inject_expect("R10 next uses new base", 1'b0, 20'h01000, 7'd9, 4'd5, 5'h00);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 16; k++) begin mdl_base[k] = '0; mdl_vld[k] = 1'b0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      tbl_write(4'd0, 40'h10_0000, 1'b1);
      tbl_write(4'd1, 40'h20_0000, 1'b1);
      tbl_write(4'd2, 40'h00_0000, 1'b1);
      tbl_write(4'd3, 40'h30_0000, 1'b0);
      tbl_write(4'd5, 40'h50_0000, 1'b1);
      tbl_write(4'd15, 40'hF0_0000, 1'b1);
      t_poll();
      t_sync_inject();
      t_flush();
      t_page_shift();
      t_bad_offset();
      t_no_base();
      t_backpressure();
      t_err_clear();
      t_tbl_collide();
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule